// File: doc/BRIEF.md
# Burst-Mode Fine Frequency Tuning Loop

This block is the fine-resolution loop of a duty-cycled digital PLL. The oscillator runs for one reference period per burst while an external counter counts its rising edges. Once per burst, on the same update strobe that the coarse loop uses, this block compares that count with the frequency control word. The comparison is a single early/late decision: a count above the control word means the extra edge arrived before the reference edge ("lead"). A count equal to the control word means it arrived after ("lag"). The block then moves a saturating fine control word that drives the fine bank of the oscillator's DAC.

The loop has two gain settings. After reset, or whenever the coarse loop reports loss of lock, it is in acquisition. In acquisition, each lag decision raises the fine word by a large step. The first lead decision is the first reversal of the decision. It moves the loop into tracking, where every burst moves the word by one LSB toward the reference edge. In steady state the word therefore alternates between two adjacent values. The fine word is held while the coarse loop is not locked.

Top module: `fine_tune_loop`

## Requirements
- R1: After a synchronous active-high reset, `fine_word` is 0 and `tracking` is 0.
- R2: A decision is taken only on a clock edge where `upd_strobe` is 1. `edge_count > fcw` is a lead. `edge_count == fcw` is a lag. `edge_count < fcw` is no decision and leaves `fine_word` and `tracking` unchanged.
- R3: In acquisition (`tracking` = 0), a lag raises `fine_word` by ACQ_STEP (default 8), and the loop stays in acquisition.
- R4: In acquisition, a lead sets `tracking` to 1 and lowers `fine_word` by 1.
- R5: In tracking, a lag raises `fine_word` by 1 and a lead lowers it by 1.
- R6: `fine_word` changes only on a strobe edge where `coarse_locked` is 1. It holds in every other cycle.
- R7: On any clock edge where `coarse_locked` is 0, `tracking` is cleared, and the loop resumes at ACQ_STEP gain once lock returns.
- R8: `fine_word` saturates at 0 and at 2^FINE_W−1 instead of wrapping.
- R9: With an oscillator whose count exceeds `fcw` exactly when `fine_word` is at or above a threshold, the loop settles so that `fine_word` alternates burst by burst between threshold−1 and threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_strobe | input | 1 | One-cycle pulse per burst, shared with the coarse loop |
| edge_count | input | CNT_W | Oscillator rising edges counted in the last burst |
| fcw | input | CNT_W | Frequency control word |
| coarse_locked | input | 1 | Coarse loop lock status |
| fine_word | output | FINE_W | Registered fine DAC control word |
| tracking | output | 1 | Registered mode: 1 for tracking, 0 for acquisition |

## Verification
The bench uses the default widths: a 9-bit fine word, a 6-bit count and an 8-LSB acquisition step. With these values the full ramp from 0 to the upper rail takes 64 bursts, which is short enough to drive the word into saturation at 511. The same widths also reach the lower rail at 0 with a lead on the first burst after reset. A behavioural oscillator with a switching threshold of 100 drives the ramp: the word passes 96, overshoots to 104, and then descends one LSB per burst until it dithers between 99 and 100. Lock loss in the middle of tracking, strobes with a short count, and unlocked strobes check the hold and mode-reset rules.

// File: rtl/ftl_pkg.sv
package ftl_pkg;
  typedef enum logic [1:0] {
    DEC_NONE = 2'd0,
    DEC_LAG  = 2'd1,
    DEC_LEAD = 2'd2
  } ftl_dec_t;
endpackage

// File: rtl/ftl_phase_decide.sv
module ftl_phase_decide #(
  parameter int CNT_W = 6
) (
  input  logic                 valid,
  input  logic [CNT_W-1:0]     edge_count,
  input  logic [CNT_W-1:0]     fcw,
  output ftl_pkg::ftl_dec_t    dec
);
  import ftl_pkg::*;

  always_comb begin
    dec = DEC_NONE;
    if (valid) begin
      if (edge_count > fcw)       dec = DEC_LEAD;
      else if (edge_count == fcw) dec = DEC_LAG;
    end
  end
endmodule

// File: rtl/ftl_bw_ctrl.sv
module ftl_bw_ctrl #(
  parameter int FINE_W   = 9,
  parameter int ACQ_STEP = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               coarse_locked,
  input  ftl_pkg::ftl_dec_t  dec,
  output logic               tracking,
  output logic               step_en,
  output logic               step_up,
  output logic [FINE_W-1:0]  step_size
);
  import ftl_pkg::*;

  localparam logic [FINE_W-1:0] STEP_ACQ = FINE_W'(ACQ_STEP);
  localparam logic [FINE_W-1:0] STEP_TRK = FINE_W'(1);

  always_comb begin
    step_en   = coarse_locked && (dec != DEC_NONE);
    step_up   = (dec == DEC_LAG);
    // A lead always moves by one LSB: in tracking, and also on the reversal that ends acquisition.
    step_size = (!tracking && dec == DEC_LAG) ? STEP_ACQ : STEP_TRK;
  end

  always_ff @(posedge clk) begin
    if (rst || !coarse_locked) tracking <= 1'b0;
    else if (dec == DEC_LEAD)  tracking <= 1'b1;
  end
endmodule

// File: rtl/ftl_accum.sv
module ftl_accum #(
  parameter int FINE_W = 9,
  parameter int INIT   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              step_up,
  input  logic [FINE_W-1:0] step_size,
  output logic [FINE_W-1:0] word
);
  localparam logic [FINE_W-1:0] MAXV = '1;
  localparam logic [FINE_W-1:0] INITV = FINE_W'(INIT);

  logic [FINE_W-1:0] nxt;

  always_comb begin
    if (step_up) nxt = (word > MAXV - step_size) ? MAXV : word + step_size;
    else         nxt = (word < step_size) ? '0 : word - step_size;
  end

  always_ff @(posedge clk) begin
    if (rst)          word <= INITV;
    else if (step_en) word <= nxt;
  end
endmodule

// File: rtl/fine_tune_loop.sv
module fine_tune_loop #(
  parameter int FINE_W   = 9,
  parameter int CNT_W    = 6,
  parameter int ACQ_STEP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_strobe,
  input  logic [CNT_W-1:0]  edge_count,
  input  logic [CNT_W-1:0]  fcw,
  input  logic              coarse_locked,
  output logic [FINE_W-1:0] fine_word,
  output logic              tracking
);
  ftl_pkg::ftl_dec_t dec;
  logic              step_en, step_up;
  logic [FINE_W-1:0] step_size;

  ftl_phase_decide #(.CNT_W(CNT_W)) u_dec (
    .valid(upd_strobe), .edge_count(edge_count), .fcw(fcw), .dec(dec)
  );

  ftl_bw_ctrl #(.FINE_W(FINE_W), .ACQ_STEP(ACQ_STEP)) u_bw (
    .clk(clk), .rst(rst), .coarse_locked(coarse_locked), .dec(dec),
    .tracking(tracking), .step_en(step_en), .step_up(step_up), .step_size(step_size)
  );

  ftl_accum #(.FINE_W(FINE_W), .INIT(0)) u_acc (
    .clk(clk), .rst(rst), .step_en(step_en), .step_up(step_up),
    .step_size(step_size), .word(fine_word)
  );
endmodule

// File: rtl/ftl_checker.sv
module ftl_checker #(
  parameter int FINE_W   = 9,
  parameter int CNT_W    = 6,
  parameter int ACQ_STEP = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              upd_strobe,
  input logic [CNT_W-1:0]  edge_count,
  input logic [CNT_W-1:0]  fcw,
  input logic              coarse_locked,
  input logic [FINE_W-1:0] fine_word,
  input logic              tracking
);
  localparam logic [FINE_W-1:0] MAXV = '1;

  // R6
  hold_without_update_chk: assert property (@(posedge clk) disable iff (rst)
    !(upd_strobe && coarse_locked) |=> $stable(fine_word));

  // R7
  unlock_clears_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !coarse_locked |=> !tracking);

  // R5
  track_unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tracking && coarse_locked) |=>
      (fine_word == $past(fine_word) || fine_word == $past(fine_word) + 1'b1 ||
       fine_word == $past(fine_word) - 1'b1));

  // R3
  acq_ramps_up_chk: assert property (@(posedge clk) disable iff (rst)
    (!tracking && upd_strobe && coarse_locked && edge_count == fcw) |=>
      (!tracking && (fine_word > $past(fine_word) || fine_word == MAXV)));

  // R4
  enter_track_on_lead_chk: assert property (@(posedge clk) disable iff (rst)
    (!tracking && upd_strobe && coarse_locked && edge_count > fcw) |=> tracking);

  // R2
  short_count_no_move_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_strobe && edge_count < fcw) |=> $stable(fine_word));
endmodule

bind fine_tune_loop ftl_checker #(.FINE_W(FINE_W), .CNT_W(CNT_W), .ACQ_STEP(ACQ_STEP)) u_chk (.*);

// File: tb/fine_tune_loop_bench.sv
module fine_tune_loop_bench;
  localparam int FINE_W = 9;
  localparam int CNT_W  = 6;
  localparam int ACQ    = 8;
  localparam int MAXW   = (1 << FINE_W) - 1;
  localparam int FCW    = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_strobe = 1'b0;
  logic [CNT_W-1:0] edge_count = '0;
  logic [CNT_W-1:0] fcw = CNT_W'(FCW);
  logic coarse_locked = 1'b0;
  logic [FINE_W-1:0] fine_word;
  logic tracking;

  int n_run = 0, n_fail = 0;
  int m_word = 0;
  int m_trk = 0;
  bit done = 0;

  typedef struct { int word; int trk; string req; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  fine_tune_loop #(.FINE_W(FINE_W), .CNT_W(CNT_W), .ACQ_STEP(ACQ)) u_fine_tune_loop (
    .clk(clk), .rst(rst), .upd_strobe(upd_strobe), .edge_count(edge_count),
    .fcw(fcw), .coarse_locked(coarse_locked), .fine_word(fine_word), .tracking(tracking)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic void model(input int cnt, input bit lk, input bit stb);
    if (!lk) begin m_trk = 0; return; end
    if (!stb || cnt < FCW) return;
    if (cnt == FCW) begin
      m_word = m_word + (m_trk ? 1 : ACQ);
      if (m_word > MAXW) m_word = MAXW;
    end else begin
      m_word = m_word - 1;
      if (m_word < 0) m_word = 0;
      m_trk = 1;
    end
  endfunction

  // Driver: one cycle of stimulus, expectation pushed to scoreboard
  task automatic cycle(input int cnt, input bit lk, input bit stb, input string req);
    exp_t e;
    @(negedge clk);
    edge_count = CNT_W'(cnt);
    coarse_locked = lk;
    upd_strobe = stb;
    model(cnt, lk, stb);
    e.word = m_word; e.trk = m_trk; e.req = req;
    q.push_back(e);
    @(negedge clk);
    upd_strobe = 1'b0;
  endtask

  function automatic int plant(input int w, input int thr);
    return (w >= thr) ? FCW + 1 : FCW;
  endfunction

  // Monitor: compare one cycle after each driven edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(int'(fine_word) == e.word, e.req, int'(fine_word), e.word);
        check(int'(tracking) == e.trk, e.req, int'(tracking), e.trk);
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    coarse_locked = 1'b0;
    upd_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_word = 0; m_trk = 0;
  endtask

  initial begin
    int prev;
    do_reset();
    // R1: reset state
    check(fine_word == '0, "R1", int'(fine_word), 0);
    check(tracking == 1'b0, "R1", int'(tracking), 0);

    // R6: unlocked strobe with lag must not move the word
    cycle(FCW, 1'b0, 1'b1, "R6");
    // R2: short count gives no decision
    cycle(FCW - 3, 1'b1, 1'b1, "R2");
    // R6: locked but no strobe
    cycle(FCW, 1'b1, 1'b0, "R6");

    // R3 and R4: acquisition ramp up to threshold 100, then reversal
    for (int i = 0; i < 14; i++)
      cycle(plant(m_word, 100), 1'b1, 1'b1, m_trk ? "R5" : "R3_R4");
    check(m_trk == 1, "R4", m_trk, 1);

    // R5 and R9: settle and verify the dither between 99 and 100
    for (int i = 0; i < 10; i++) cycle(plant(m_word, 100), 1'b1, 1'b1, "R5");
    prev = int'(fine_word);
    for (int i = 0; i < 8; i++) begin
      cycle(plant(m_word, 100), 1'b1, 1'b1, "R9");
      check((int'(fine_word) == 99 || int'(fine_word) == 100) &&
            (int'(fine_word) - prev == 1 || prev - int'(fine_word) == 1),
            "R9", int'(fine_word), (prev == 99) ? 100 : 99);
      prev = int'(fine_word);
    end

    // R7: lock loss clears tracking, word held; relock gives large step
    cycle(FCW, 1'b0, 1'b0, "R7");
    check(tracking == 1'b0, "R7", int'(tracking), 0);
    cycle(FCW, 1'b1, 1'b1, "R7");

    // R8: ramp to the upper rail
    for (int i = 0; i < 70; i++) cycle(FCW, 1'b1, 1'b1, "R8");
    check(int'(fine_word) == MAXW, "R8", int'(fine_word), MAXW);

    // R8: lower rail, lead on the first burst after reset
    @(negedge clk);
    do_reset();
    cycle(FCW + 1, 1'b1, 1'b1, "R8");
    cycle(FCW + 1, 1'b1, 1'b1, "R8");
    check(fine_word == '0, "R8", int'(fine_word), 0);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule